// File: doc/BRIEF.md
# Radio Command Serial Master

This block shifts 16-bit configuration words out to a radio transceiver over a four-wire serial link and collects the 16 bits the radio returns during the same transfer. A host starts a transfer in one of two ways. It can present a complete command word with a one-cycle strobe. It can also present a single payload byte with a second strobe. In that case the block builds the radio's data-write command from the byte and holds it until the radio's active-low interrupt line reports that the radio is ready to take data.

The serial clock runs from a half-period counter set in system clocks. The frame is always 16 bits and goes out most significant bit first. A new output bit is placed on the line while the serial clock is low. The returning bit is captured during the high phase. The captured word appears on the response output when the frame closes, together with a one-cycle completion pulse.

Top module: `radio_cmd_spi`

## Requirements
- R1: After reset, and whenever no frame is in progress, cs_n is 1, sclk is 0, mosi is 1, busy is 0 and resp_out is 0 until the first frame completes.
- R2: Every frame has exactly 16 sclk rising edges, and the mosi level at the k-th rising edge (k = 1..16) equals bit 16-k of the command word, so the most significant bit goes first.
- R3: sclk is 0 whenever cs_n is 1, including the cycle in which cs_n falls and the last cycle before cs_n rises.
- R4: mosi does not change while sclk stays high; it changes only while sclk is low.
- R5: The miso level in the final system clock of each sclk high phase is shifted in at bit 0, so the bit sampled on the first rising edge ends at resp_out bit 15. resp_out changes only in the cycle done is 1 and holds its value during the next frame.
- R6: Every sclk high phase, every low phase between bits, the lead-in from cs_n falling to the first rising edge, and the tail from the last falling edge to cs_n rising each last HALF_CLKS system clocks. HALF_CLKS may be 1. cs_n is therefore low for 33 × HALF_CLKS cycles per frame.
- R7: done is 1 for exactly one cycle, the first cycle in which cs_n is 1 again after a frame, and busy is 0 in that cycle. busy is 1 from the cycle after an accepted start until the end of the frame.
- R8: A start_cmd or start_wr strobe that arrives while busy is 1 has no effect. The running frame keeps its word, and no extra frame follows.
- R9: A start_wr strobe sends the word with bits 15:8 = 0xB8 and bits 7:0 = wr_byte.
- R10: After start_wr, busy is 1 and cs_n stays 1 for as long as irq_n is 1. The frame starts within a few cycles of irq_n being 0, after a synchronizer of SYNC_STAGES flops.
- R11: If start_cmd and start_wr are both 1 in the same idle cycle, the command word is sent at once and the write request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_word | input | 16 | Command word, sampled with start_cmd |
| start_cmd | input | 1 | One-cycle strobe that sends cmd_word |
| wr_byte | input | 8 | Payload byte, sampled with start_wr |
| start_wr | input | 1 | One-cycle strobe that sends a data-write command |
| irq_n | input | 1 | Active-low ready line from the radio (asynchronous) |
| busy | output | 1 | A request is waiting or a frame is in progress |
| done | output | 1 | One-cycle pulse when the frame closes |
| resp_out | output | 16 | Word received during the last frame |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the radio |
| miso | input | 1 | Serial data from the radio |

## Verification
Command words are sent against response patterns that are all zeros, all ones, alternating, and a word whose only set bits are the two ends. This makes a reversed bit order, an off-by-one shift or a stuck bit show up on both lines. A bus monitor rebuilds the sent word from mosi at each rising edge, measures every clock phase and the length of the select window, and drives miso bit by bit so the captured word can be compared with the pattern. Further cases cover a write held back by the ready line, extra strobes during a running frame, and two strobes in the same cycle. Each of these separates correct arbitration from a queued or swapped request.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam int FRAME_BITS = 16;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam logic [7:0] WRITE_OPCODE = 8'hB8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_SETUP = 3'd2,
        ST_HIGH  = 3'd3,
        ST_TAIL  = 3'd4
    } rcs_state_e;

    typedef struct packed {
        logic [FRAME_BITS-1:0] tx;
        logic [FRAME_BITS-1:0] rx;
    } rcs_shift_t;

    function automatic logic [FRAME_BITS-1:0] form_write(input logic [7:0] data);
        return {WRITE_OPCODE, data};
    endfunction

    function automatic logic in_frame(input rcs_state_e s);
        return (s == ST_SETUP) || (s == ST_HIGH) || (s == ST_TAIL);
    endfunction

endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/rcs_halftimer.sv
module rcs_halftimer #(
    parameter int HALF_CLKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (HALF_CLKS <= 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_CLKS);
            localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);
            logic [CW-1:0] cnt;

            assign tick = run && (cnt == LAST);

            always_ff @(posedge clk) begin
                if (rst || !run) cnt <= '0;
                else if (tick)   cnt <= '0;
                else             cnt <= cnt + CW'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/rcs_shift.sv
module rcs_shift import rcs_pkg::*; (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_word,
    input  logic                  shift,
    input  logic                  rx_bit,
    output logic                  tx_msb,
    output logic [FRAME_BITS-1:0] rx_word
);
    rcs_shift_t sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr.tx <= '1;
            sr.rx <= '0;
        end else if (load) begin
            sr.tx <= load_word;
            sr.rx <= '0;
        end else if (shift) begin
            sr.tx <= {sr.tx[FRAME_BITS-2:0], 1'b1};
            sr.rx <= {sr.rx[FRAME_BITS-2:0], rx_bit};
        end
    end

    assign tx_msb  = sr.tx[FRAME_BITS-1];
    assign rx_word = sr.rx;
endmodule

// File: rtl/radio_cmd_spi.sv
module radio_cmd_spi import rcs_pkg::*; #(
    parameter int HALF_CLKS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FRAME_BITS-1:0] cmd_word,
    input  logic                  start_cmd,
    input  logic [7:0]            wr_byte,
    input  logic                  start_wr,
    input  logic                  irq_n,
    output logic                  busy,
    output logic                  done,
    output logic [FRAME_BITS-1:0] resp_out,
    output logic                  cs_n,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    rcs_state_e            state;
    logic [BIT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] wr_word;
    logic [FRAME_BITS-1:0] load_word;
    logic [FRAME_BITS-1:0] rx_word;
    logic                  irq_q;
    logic                  run;
    logic                  tick;
    logic                  load;
    logic                  shift_en;
    logic                  tx_msb;

    rcs_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (irq_n),
        .dout (irq_q)
    );

    rcs_halftimer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    rcs_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_word (load_word),
        .shift     (shift_en),
        .rx_bit    (miso),
        .tx_msb    (tx_msb),
        .rx_word   (rx_word)
    );

    always_comb begin
        run       = in_frame(state);
        load      = ((state == ST_IDLE) && start_cmd) ||
                    ((state == ST_WAIT) && !irq_q);
        load_word = (state == ST_IDLE) ? cmd_word : wr_word;
        shift_en  = (state == ST_HIGH) && tick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            wr_word  <= '0;
            done     <= 1'b0;
            resp_out <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    if (start_cmd) begin
                        state <= ST_SETUP;
                    end else if (start_wr) begin
                        wr_word <= form_write(wr_byte);
                        state   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!irq_q) state <= ST_SETUP;
                end
                ST_SETUP: begin
                    if (tick) state <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (tick) begin
                        bit_cnt <= bit_cnt + BIT_W'(1);
                        state   <= (bit_cnt == LAST_BIT) ? ST_TAIL : ST_SETUP;
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        state    <= ST_IDLE;
                        done     <= 1'b1;
                        resp_out <= rx_word;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign cs_n = !run;
    assign sclk = (state == ST_HIGH);
    assign mosi = run ? tx_msb : 1'b1;

endmodule

// File: rtl/radio_cmd_spi_chk.sv
module radio_cmd_spi_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        sclk,
    input logic        mosi,
    input logic        busy,
    input logic        done,
    input logic [15:0] resp_out
);
    // R3: no clock activity while deselected
    a_r3_clock_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R3: select edges only with clock low
    a_r3_select_edge_clock_low: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) || $rose(cs_n)) |-> (!sclk && !$past(sclk)));

    // R1: data line idles high
    a_r1_idle_mosi_high: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> mosi);

    // R4: data steady through a high phase
    a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R7: completion coincides with deselect
    a_r7_done_at_deselect: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !$past(cs_n) && !busy));

    // R7: completion lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: response only moves with completion
    a_r5_resp_held: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(resp_out));
endmodule

bind radio_cmd_spi radio_cmd_spi_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .busy     (busy),
    .done     (done),
    .resp_out (resp_out)
);

// File: tb/radio_cmd_spi_bench.sv
module radio_cmd_spi_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cmd_word = '0;
    logic        start_cmd = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        start_wr = 1'b0;
    logic        irq_n = 1'b1;
    logic        busy, done, cs_n, sclk, mosi;
    logic        miso = 1'b0;
    logic [15:0] resp_out;

    int total = 0;
    int bad   = 0;

    radio_cmd_spi #(.HALF_CLKS(HALF), .SYNC_STAGES(2)) u_radio_cmd_spi (
        .clk(clk), .rst(rst), .cmd_word(cmd_word), .start_cmd(start_cmd),
        .wr_byte(wr_byte), .start_wr(start_wr), .irq_n(irq_n),
        .busy(busy), .done(done), .resp_out(resp_out),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bus monitor and radio model, evaluated mid-cycle
    logic [15:0] pat = '0;
    logic [15:0] mon_word = '0;
    int mon_rises = 0, mon_low = 0, mon_run = 0, mon_frames = 0;
    int bad_half = 0, bad_level = 0, bad_mosi = 0, done_cnt = 0, done_bad = 0;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_cs && !cs_n) begin
                mon_frames++;
                mon_rises = 0; mon_word = '0; mon_low = 0; mon_run = 0;
                if (sclk) bad_level++;
            end
            if (!cs_n) begin
                mon_low++;
                if (p_cs) mon_run = 1;
                else if (sclk != p_sclk) begin
                    if (mon_run != HALF) bad_half++;
                    mon_run = 1;
                end else mon_run++;
                if (sclk && !p_sclk) begin
                    mon_word = {mon_word[14:0], mosi};
                    mon_rises++;
                    if (mon_rises >= 1 && mon_rises <= 16) miso = pat[16 - mon_rises];
                end
                if (sclk && p_sclk && (mosi != p_mosi)) bad_mosi++;
            end
            if (!p_cs && cs_n) begin
                if (mon_run != HALF) bad_half++;
                if (p_sclk) bad_level++;
                if (!done) done_bad++;
            end
            if (cs_n && sclk) bad_level++;
            if (done) begin
                done_cnt++;
                if (!(cs_n && !p_cs) || busy) done_bad++;
            end
        end
        p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output bit ok);
        int start_cnt;
        start_cnt = done_cnt;
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done_cnt != start_cnt) begin ok = 1'b1; break; end
        end
    endtask

    task automatic pulse_cmd(input logic [15:0] w);
        @(negedge clk);
        cmd_word = w; start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 cs_n idle", 32'(cs_n), 32'd1);
        check("R1 sclk idle", 32'(sclk), 32'd0);
        check("R1 mosi idle", 32'(mosi), 32'd1);
        check("R1 busy idle", 32'(busy), 32'd0);
        check("R1 resp reset", 32'(resp_out), 32'd0);
        check("R7 done idle", 32'(done), 32'd0);
    endtask

    task automatic t_frame(input logic [15:0] w, input logic [15:0] p);
        bit ok;
        int fr, dc, bh, bl, bm, db;
        fr = mon_frames; dc = done_cnt; bh = bad_half; bl = bad_level; bm = bad_mosi; db = done_bad;
        pat = p;
        pulse_cmd(w);
        check("R7 busy after start", 32'(busy), 32'd1);
        wait_done(ok);
        check("R7 frame completed", 32'(ok), 32'd1);
        check("R2 word sent msb first", 32'(mon_word), 32'(w));
        check("R2 sixteen rising edges", 32'(mon_rises), 32'd16);
        check("R5 response captured", 32'(resp_out), 32'(p));
        check("R6 select window", 32'(mon_low), 32'(33 * HALF));
        check("R6 phase lengths", 32'(bad_half - bh), 32'd0);
        check("R3 clock low at select edges", 32'(bad_level - bl), 32'd0);
        check("R4 mosi steady while high", 32'(bad_mosi - bm), 32'd0);
        check("R7 single done", 32'(done_cnt - dc), 32'd1);
        check("R7 done at deselect", 32'(done_bad - db), 32'd0);
        check("R2 one frame", 32'(mon_frames - fr), 32'd1);
        @(negedge clk);
        check("R7 done one cycle", 32'(done), 32'd0);
        check("R1 idle after frame", 32'({cs_n, sclk, mosi, busy}), 32'b1010);
    endtask

    task automatic t_ignore_busy;
        bit ok;
        int fr;
        logic [15:0] old_resp;
        old_resp = resp_out;
        fr = mon_frames;
        pat = 16'hC3A5;
        pulse_cmd(16'h3C96);
        repeat (10) @(negedge clk);
        cmd_word = 16'h0F0F; start_cmd = 1'b1; wr_byte = 8'h11; start_wr = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0; start_wr = 1'b0;
        check("R8 busy during frame", 32'(busy), 32'd1);
        check("R5 resp held during frame", 32'(resp_out), 32'(old_resp));
        wait_done(ok);
        check("R8 original word kept", 32'(mon_word), 32'h3C96);
        check("R5 new response", 32'(resp_out), 32'hC3A5);
        repeat (40) @(negedge clk);
        check("R8 no extra frame", 32'(mon_frames - fr), 32'd1);
        check("R8 idle afterwards", 32'(busy), 32'd0);
    endtask

    task automatic t_write(input logic [7:0] b);
        bit ok;
        int fr;
        fr = mon_frames;
        pat = 16'h00FF;
        irq_n = 1'b1;
        @(negedge clk);
        wr_byte = b; start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        repeat (30) @(negedge clk);
        check("R10 held while irq high", 32'(cs_n), 32'd1);
        check("R10 busy while waiting", 32'(busy), 32'd1);
        check("R10 no frame yet", 32'(mon_frames - fr), 32'd0);
        irq_n = 1'b0;
        wait_done(ok);
        irq_n = 1'b1;
        check("R10 frame after irq low", 32'(ok), 32'd1);
        check("R9 write word", 32'(mon_word), 32'({8'hB8, b}));
        check("R5 write response", 32'(resp_out), 32'h00FF);
    endtask

    task automatic t_both_strobes;
        bit ok;
        pat = 16'h1357;
        irq_n = 1'b1;
        @(negedge clk);
        cmd_word = 16'h1234; start_cmd = 1'b1; wr_byte = 8'h99; start_wr = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0; start_wr = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 command starts at once", 32'(cs_n), 32'd0);
        wait_done(ok);
        check("R11 command word sent", 32'(mon_word), 32'h1234);
        repeat (20) @(negedge clk);
        check("R11 write dropped", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 0 + 200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_frame(16'hA640, 16'h5A3C);
        t_frame(16'h0000, 16'hFFFF);
        t_frame(16'hFFFF, 16'h0000);
        t_frame(16'h8001, 16'h8001);
        t_frame(16'h5555, 16'hAAAA);
        t_ignore_busy();
        t_write(8'h5D);
        t_write(8'h00);
        t_both_strobes();
        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule